// File: doc/BRIEF.md
# Receiver Acquisition Mode Sequencer

This block sequences the fast-acquisition phases of a four-level FSK receiver. It sets the mode of two loops. One is the level-measurement loop, which tracks amplitude and DC offset. The other is the symbol-timing PLL, through its loop bandwidth. Each loop has its own start strobe. Once started, a timed sequence of modes steps forward on the receiver's symbol-clock strobe. The level sequence runs Clamp, then Lossy Peak Detect, then Slow Peak Detect. It stays in Slow Peak Detect until a frame-sync detection pulse arrives. The bandwidth sequence runs an Extra Wide phase and then a Wide phase, and returns control by itself after a fixed symbol count.

While a sequence is idle, the mode fields written by software pass straight through to the matching output. The Extra Wide bandwidth code cannot be produced from the 2-bit software field, so it is visible only during an active clock sequence. Either sequence may be started at any point in a transmission and behaves the same way. The two sequences are independent and may overlap.

Top module: `rx_acq_sequencer`

## Requirements
- R1: After a synchronous reset, both busy flags are 0, `lvl_mode` equals `reg_lvl_mode` and `bw_mode` equals `{1'b0, reg_bw_mode}`.
- R2: A `lvl_start` pulse sets `lvl_mode` to Clamp (2'd1) from the next cycle. The mode stays Clamp until the first `sym_tick`. It then becomes Lossy (2'd2) and stays there for 15 further ticks.
- R3: On the 16th tick after the start, `lvl_mode` becomes Slow (2'd3). It stays Slow with no time limit until `fsync` is seen.
- R4: An `fsync` pulse during Slow ends the level sequence, whether or not a tick comes in the same cycle. `lvl_busy` drops and `lvl_mode` returns to `reg_lvl_mode`. An `fsync` pulse during Clamp or Lossy, including the cycle of the tick that ends Lossy, has no effect.
- R5: A `clk_start` pulse sets `bw_mode` to Extra Wide (3'b100) from the next cycle. Extra Wide holds until the 16th `sym_tick` after the start.
- R6: From the 16th tick after the start, `bw_mode` is Wide (3'b010). On the 45th tick it returns to `{1'b0, reg_bw_mode}` and `clk_busy` drops.
- R7: While a sequence is idle, its output follows its register field in the same cycle. While a sequence is active, its register field has no effect on the output.
- R8: A start pulse during an active sequence restarts that sequence from its first phase with the tick count at zero. This also holds when a `sym_tick` arrives in the same cycle.
- R9: The two sequences are independent. Starting, advancing or ending one never changes the other's output or busy flag.
- R10: A synchronous reset aborts both active sequences and returns them to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_tick | input | 1 | One-cycle strobe per received symbol |
| fsync | input | 1 | One-cycle pulse when a frame sync is recognised |
| lvl_start | input | 1 | Start strobe for the level acquisition sequence |
| clk_start | input | 1 | Start strobe for the clock acquisition sequence |
| reg_lvl_mode | input | 2 | Software-selected level-measurement mode |
| reg_bw_mode | input | 2 | Software-selected PLL bandwidth mode |
| lvl_mode | output | 2 | Level mode: 1 Clamp, 2 Lossy, 3 Slow while active |
| bw_mode | output | 3 | PLL bandwidth: 3'b100 Extra Wide, 3'b010 Wide while active |
| lvl_busy | output | 1 | Level sequence active (self-clearing trigger bit) |
| clk_busy | output | 1 | Clock sequence active (self-clearing trigger bit) |

## Verification
Two pairs of events can fall in one cycle, and the bench provokes both. The first pair is a start strobe and a symbol tick. The bench issues a restart on the same cycle as a tick, for each sequence, and requires the output to show the first phase. It then requires the full first-phase length to follow, counted from zero. The second pair is a frame-sync pulse and the tick that moves Lossy to Slow. The bench requires that pulse to be dropped, so the level output must stay Slow afterwards.

// File: rtl/rx_acq_pkg.sv
package rx_acq_pkg;

    // Level-measurement output codes used while a sequence is active
    localparam logic [1:0] LVL_CLAMP = 2'd1;
    localparam logic [1:0] LVL_LOSSY = 2'd2;
    localparam logic [1:0] LVL_SLOW  = 2'd3;

    // PLL bandwidth output codes used while a sequence is active
    localparam logic [2:0] BW_WIDE   = 3'b010;
    localparam logic [2:0] BW_XWIDE  = 3'b100;

    typedef enum logic [1:0] {
        LP_IDLE,
        LP_CLAMP,
        LP_LOSSY,
        LP_SLOW
    } lvl_phase_e;

    typedef enum logic [1:0] {
        PP_IDLE,
        PP_XWIDE,
        PP_WIDE
    } pll_phase_e;

endpackage

// File: rtl/rx_lvl_acq_seq.sv
module rx_lvl_acq_seq
    import rx_acq_pkg::*;
#(
    parameter int CLAMP_SYMS = 1,
    parameter int LOSSY_SYMS = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_tick,
    input  logic       fsync,
    input  logic       start,
    input  logic [1:0] reg_mode,
    output logic [1:0] mode,
    output logic       busy
);

    localparam int MAX_SYMS = (LOSSY_SYMS > CLAMP_SYMS) ? LOSSY_SYMS : CLAMP_SYMS;
    localparam int CW       = $clog2(MAX_SYMS + 1);

    typedef struct packed {
        lvl_phase_e     phase;
        logic [CW-1:0]  cnt;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.phase = LP_CLAMP;
            st_d.cnt   = '0;
        end else begin
            case (st_q.phase)
                LP_CLAMP: if (sym_tick) begin
                    if (st_q.cnt == CW'(CLAMP_SYMS - 1)) begin
                        st_d.phase = LP_LOSSY;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                LP_LOSSY: if (sym_tick) begin
                    if (st_q.cnt == CW'(LOSSY_SYMS - 1)) begin
                        st_d.phase = LP_SLOW;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                LP_SLOW: if (fsync) begin
                    st_d.phase = LP_IDLE;
                    st_d.cnt   = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= LP_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.phase)
            LP_CLAMP: mode = LVL_CLAMP;
            LP_LOSSY: mode = LVL_LOSSY;
            LP_SLOW:  mode = LVL_SLOW;
            default:  mode = reg_mode;
        endcase
    end

    assign busy = (st_q.phase != LP_IDLE);

    AST_LOSSY_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == LP_LOSSY) |-> (st_q.cnt < CW'(LOSSY_SYMS))); // R2
    AST_SLOW_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == LP_SLOW && !fsync && !start) |=> (mode == LVL_SLOW)); // R3
    AST_FSYNC_ENDS_SLOW: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == LP_SLOW && fsync && !start) |=> !busy); // R4
    AST_EARLY_FSYNC_IGNORED: assert property (@(posedge clk) disable iff (rst)
        ((st_q.phase == LP_CLAMP || st_q.phase == LP_LOSSY) && fsync) |=> busy); // R4
    AST_START_CLAMP: assert property (@(posedge clk) disable iff (rst)
        start |=> (mode == LVL_CLAMP)); // R8

endmodule

// File: rtl/rx_pll_acq_seq.sv
module rx_pll_acq_seq
    import rx_acq_pkg::*;
#(
    parameter int XWIDE_SYMS = 16,
    parameter int TOTAL_SYMS = 45
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_tick,
    input  logic       start,
    input  logic [1:0] reg_bw,
    output logic [2:0] bw_mode,
    output logic       busy
);

    localparam int CW = $clog2(TOTAL_SYMS + 1);

    typedef struct packed {
        pll_phase_e     phase;
        logic [CW-1:0]  cnt;
    } pll_state_t;

    pll_state_t    st_d, st_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = st_q.cnt + 1'b1;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.phase = PP_XWIDE;
            st_d.cnt   = '0;
        end else if (sym_tick) begin
            case (st_q.phase)
                PP_XWIDE: begin
                    st_d.cnt = cnt_inc;
                    if (cnt_inc == CW'(XWIDE_SYMS)) begin
                        st_d.phase = PP_WIDE;
                    end
                end
                PP_WIDE: begin
                    if (cnt_inc == CW'(TOTAL_SYMS)) begin
                        st_d.phase = PP_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = cnt_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PP_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.phase)
            PP_XWIDE: bw_mode = BW_XWIDE;
            PP_WIDE:  bw_mode = BW_WIDE;
            default:  bw_mode = {1'b0, reg_bw};
        endcase
    end

    assign busy = (st_q.phase != PP_IDLE);

    AST_XWIDE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (bw_mode == BW_XWIDE) |-> busy); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < CW'(TOTAL_SYMS)); // R6
    AST_WIDE_AFTER_XWIDE: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PP_WIDE) |-> (st_q.cnt >= CW'(XWIDE_SYMS))); // R6
    AST_RESTART_XWIDE: assert property (@(posedge clk) disable iff (rst)
        start |=> (bw_mode == BW_XWIDE && st_q.cnt == '0)); // R8

endmodule

// File: rtl/rx_acq_sequencer.sv
module rx_acq_sequencer #(
    parameter int CLAMP_SYMS = 1,
    parameter int LOSSY_SYMS = 15,
    parameter int XWIDE_SYMS = 16,
    parameter int TOTAL_SYMS = 45
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_tick,
    input  logic       fsync,
    input  logic       lvl_start,
    input  logic       clk_start,
    input  logic [1:0] reg_lvl_mode,
    input  logic [1:0] reg_bw_mode,
    output logic [1:0] lvl_mode,
    output logic [2:0] bw_mode,
    output logic       lvl_busy,
    output logic       clk_busy
);

    // Two independent sequencers share only the symbol strobe (R9)
    rx_lvl_acq_seq #(
        .CLAMP_SYMS (CLAMP_SYMS),
        .LOSSY_SYMS (LOSSY_SYMS)
    ) i_lvl_seq (
        .clk      (clk),
        .rst      (rst),
        .sym_tick (sym_tick),
        .fsync    (fsync),
        .start    (lvl_start),
        .reg_mode (reg_lvl_mode),
        .mode     (lvl_mode),
        .busy     (lvl_busy)
    );

    rx_pll_acq_seq #(
        .XWIDE_SYMS (XWIDE_SYMS),
        .TOTAL_SYMS (TOTAL_SYMS)
    ) i_pll_seq (
        .clk      (clk),
        .rst      (rst),
        .sym_tick (sym_tick),
        .start    (clk_start),
        .reg_bw   (reg_bw_mode),
        .bw_mode  (bw_mode),
        .busy     (clk_busy)
    );

endmodule

// File: tb/test_rx_acq_sequencer.sv
module test_rx_acq_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_tick = 1'b0;
    logic       fsync = 1'b0;
    logic       lvl_start = 1'b0;
    logic       clk_start = 1'b0;
    logic [1:0] reg_lvl_mode = 2'd0;
    logic [1:0] reg_bw_mode = 2'd1;
    logic [1:0] lvl_mode;
    logic [2:0] bw_mode;
    logic       lvl_busy;
    logic       clk_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_acq_sequencer i_rx_acq_sequencer (
        .clk          (clk),
        .rst          (rst),
        .sym_tick     (sym_tick),
        .fsync        (fsync),
        .lvl_start    (lvl_start),
        .clk_start    (clk_start),
        .reg_lvl_mode (reg_lvl_mode),
        .reg_bw_mode  (reg_bw_mode),
        .lvl_mode     (lvl_mode),
        .bw_mode      (bw_mode),
        .lvl_busy     (lvl_busy),
        .clk_busy     (clk_busy)
    );

    // Vector: [14] lvl_start [13] clk_start [12] tick [11] fsync [10:9] reg_lvl
    //         [8:7] reg_bw [6:5] exp lvl [4:2] exp bw [1] exp lvl_busy [0] exp clk_busy
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 3'b001, 1'b0, 1'b0}, // R1 idle
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd3, 2'd2, 3'b011, 1'b0, 1'b0}, // R7 pass-through
        {1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 2'd1, 3'b100, 1'b1, 1'b1}, // R2 R5 start both
        {1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 2'd1, 3'b100, 1'b1, 1'b1}, // R4 fsync in clamp
        {1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1, 2'd2, 3'b100, 1'b1, 1'b1}, // R2 first tick
        {1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 2'd2, 3'b100, 1'b1, 1'b1}, // R4 fsync in lossy
        {1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1, 2'd2, 3'b100, 1'b1, 1'b1}, // R2 tick 2
        {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 2'd2, 3'b100, 1'b1, 1'b1}  // R7 reg ignored
    };

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input logic ls, input logic cs, input logic tk, input logic fs);
        @(negedge clk);
        lvl_start = ls;
        clk_start = cs;
        sym_tick  = tk;
        fsync     = fs;
        @(posedge clk);
        #2;
        lvl_start = 1'b0;
        clk_start = 1'b0;
        sym_tick  = 1'b0;
        fsync     = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 lvl_busy", {2'b0, lvl_busy}, 3'd0);
        chk("R1 clk_busy", {2'b0, clk_busy}, 3'd0);
        @(negedge clk);
        rst = 1'b0;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            lvl_start    = VEC[v][14];
            clk_start    = VEC[v][13];
            sym_tick     = VEC[v][12];
            fsync        = VEC[v][11];
            reg_lvl_mode = VEC[v][10:9];
            reg_bw_mode  = VEC[v][8:7];
            @(posedge clk);
            #2;
            chk($sformatf("vec%0d lvl_mode", v), {1'b0, lvl_mode}, {1'b0, VEC[v][6:5]});
            chk($sformatf("vec%0d bw_mode", v), bw_mode, VEC[v][4:2]);
            chk($sformatf("vec%0d lvl_busy", v), {2'b0, lvl_busy}, {2'b0, VEC[v][1]});
            chk($sformatf("vec%0d clk_busy", v), {2'b0, clk_busy}, {2'b0, VEC[v][0]});
            lvl_start = 1'b0;
            clk_start = 1'b0;
            sym_tick  = 1'b0;
            fsync     = 1'b0;
        end
        reg_lvl_mode = 2'd0;
        reg_bw_mode  = 2'd1;

        // Ticks 3..16; fsync on tick 16 (end of Lossy) must be ignored
        for (int t = 3; t <= 16; t++) begin
            step(1'b0, 1'b0, 1'b1, (t == 16));
            if (t < 16) begin
                chk("R2 lossy", {1'b0, lvl_mode}, 3'd2);
                chk("R5 xwide", bw_mode, 3'b100);
            end else begin
                chk("R3 slow at tick 16 (R4 fsync ignored)", {1'b0, lvl_mode}, 3'd3);
                chk("R6 wide at tick 16", bw_mode, 3'b010);
            end
        end
        for (int t = 17; t <= 44; t++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0);
            chk("R6 wide", bw_mode, 3'b010);
        end
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 revert at tick 45", bw_mode, 3'b001);
        chk("R6 clk_busy clears", {2'b0, clk_busy}, 3'd0);
        chk("R9 lvl unaffected", {1'b0, lvl_mode}, 3'd3);

        // Slow holds without fsync
        for (int t = 0; t < 20; t++) step(1'b0, 1'b0, (t % 2 == 0), 1'b0);
        chk("R3 slow holds", {1'b0, lvl_mode}, 3'd3);
        chk("R3 busy holds", {2'b0, lvl_busy}, 3'd1);

        // fsync together with tick in Slow ends the sequence
        step(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R4 ends to reg", {1'b0, lvl_mode}, 3'd0);
        chk("R4 lvl_busy clears", {2'b0, lvl_busy}, 3'd0);
        reg_lvl_mode = 2'd2;
        #1;
        chk("R7 idle pass-through", {1'b0, lvl_mode}, 3'd2);
        reg_lvl_mode = 2'd0;

        // Level alone; clock output stays pass-through; restart with tick
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 clamp", {1'b0, lvl_mode}, 3'd1);
        for (int t = 1; t <= 16; t++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0);
            chk("R9 bw untouched", bw_mode, 3'b001);
        end
        chk("R3 slow", {1'b0, lvl_mode}, 3'd3);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R8 restart beats tick", {1'b0, lvl_mode}, 3'd1);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 restart count from zero", {1'b0, lvl_mode}, 3'd2);

        // Clock restart mid-Wide, same cycle as tick
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5 xwide", bw_mode, 3'b100);
        for (int t = 1; t <= 30; t++) step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 wide", bw_mode, 3'b010);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 clk restart beats tick", bw_mode, 3'b100);
        for (int t = 1; t <= 15; t++) step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 xwide full length", bw_mode, 3'b100);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 wide after 16", bw_mode, 3'b010);
        chk("R9 lvl still busy", {2'b0, lvl_busy}, 3'd1);

        // Synchronous reset aborts both
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
        chk("R10 lvl idle", {1'b0, lvl_mode}, 3'd0);
        chk("R10 bw idle", bw_mode, 3'b001);
        chk("R10 busy", {1'b0, lvl_busy, clk_busy}, 3'd0);
        step(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 stays idle", {1'b0, lvl_busy, clk_busy}, 3'd0);
        chk("R4 fsync idle no effect", {1'b0, lvl_mode}, 3'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule